// File: doc/BRIEF.md
# Interrupt factor flag controller

This block keeps the pending-event flags of a two-channel serial bus peripheral and turns them into one prioritised interrupt request for the CPU. Each channel owns three sources: a command finished or failed event, a receive-side DMA request and a send-side DMA request. A one-cycle pulse from the protocol engine raises a flag. Only a software write lowers it. A mode input chooses how writes act: in clear-only mode a 1 lowers a flag, and in read/write mode the written value replaces the flag.

A pending flag takes part in arbitration when its enable bit is set. It must also have a 3-bit priority above the current CPU interrupt level, and the global interrupt enable must be on. The highest priority wins, and equal priorities go to the lowest bit index. The block drives the request, the winning level and the winning source index.

The DMA sources can be handed to the DMA engine. While a routed flag waits for its transfer, it stays invisible to the CPU. When the DMA engine reports completion, the flag competes normally until software lowers it. The flags power up with a build-time value that stands in for unknown contents, so software must clear them before use.

Top module: `ifc_flag_ctrl`

## Requirements
- R1: Flag bit layout: channel 0 uses bit 0 (complete/error), bit 1 (receive DMA) and bit 2 (send DMA). Channel 1 uses bits 3, 4 and 5 in the same order. `rdData` returns the flags in bits 5:0 and zeros above them.
- R2: An `evtSet[i]` pulse makes flag i read 1 after the next clock edge, whatever the enable, priority and level inputs are.
- R3: Without an event and without a write, a flag keeps its value. A flag left set keeps requesting whenever the request conditions hold again.
- R4: With `clearOnly`=1, a write lowers every flag whose `wrData` bit is 1 and leaves flags whose bit is 0 unchanged.
- R5: With `clearOnly`=0, a write loads each flag with its `wrData` bit, so a 1 raises it and a 0 lowers it.
- R6: If an event and a software clear hit the same flag in the same cycle, the flag ends up 1.
- R7: A flag takes part in the request only when it is set, its `srcEnable` bit is 1, `globalIe` is 1 and its priority is strictly greater than `cpuLevel`.
- R8: Among the candidates, `irqSrc` is the index of the one with the highest priority, with ties going to the lowest index. `irqLevel` is that candidate's priority. With no request, `irqReq`=0 and `irqLevel`=`irqSrc`=0.
- R9: When the `dmaRoute` bit of a DMA source (bits 1, 2, 4, 5) is 1, a newly raised flag does not request until a `dmaDone` pulse arrives for it. After that pulse it requests under R7 until it is lowered. `dmaRoute` has no effect on bits 0 and 3.
- R10: Reset loads the flags with the parameter `FLAG_INIT`. A set bit there acts as a real pending event until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, loads FLAG_INIT |
| evtSet | input | 6 | One-cycle event pulses, one per flag |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 6 | Software write value |
| clearOnly | input | 1 | Write mode: 1 clear-only, 0 read/write |
| rdData | output | DATA_W | Flag read value, zero-extended |
| srcEnable | input | 6 | Per-source interrupt enable |
| srcPrio | input | 18 | Per-source 3-bit priority, source i at bits 3i+2:3i |
| globalIe | input | 1 | CPU global interrupt enable |
| cpuLevel | input | 3 | Current CPU interrupt level |
| dmaRoute | input | 6 | Route DMA-source flag to the DMA engine |
| dmaDone | input | 6 | DMA transfer-complete pulse per flag |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqLevel | output | 3 | Priority of the winning source |
| irqSrc | output | 3 | Index of the winning source |

## Verification
Directed patterns come first. A reset value with stale bits shows whether the power-up contents really request. Writes of 1s and 0s in both modes separate clear-only behaviour from read/write behaviour. An event that collides with a clear shows which side wins. Priority sets with a tie, with one source exactly at `cpuLevel` and with `globalIe` low separate the strict comparison and the index tie-break. A routed DMA flag raised before and after its completion pulse shows the hold-off. A long random phase then mixes every input, and a behavioural model checks the read value and all three request outputs on every clock.

// File: rtl/ifc_pkg.sv
`timescale 1ns/1ps
package ifc_pkg;
  localparam int NUM_CH     = 2;
  localparam int SRC_PER_CH = 3;
  localparam int NSRC       = NUM_CH * SRC_PER_CH;
  localparam int PRIO_W     = 3;
  localparam int SRC_IDX_W  = $clog2(NSRC);

  // Strobes from write control to the flag datapath
  typedef struct packed {
    logic [NSRC-1:0] setMask;
    logic [NSRC-1:0] clrMask;
  } wr_strobe_t;

  // Sources other than the first of each channel are DMA requests
  function automatic logic [NSRC-1:0] dma_src_mask();
    logic [NSRC-1:0] m;
    m = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      for (int k = 1; k < SRC_PER_CH; k++)
        m[ch*SRC_PER_CH + k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ifc_wr_ctrl.sv
`timescale 1ns/1ps
module ifc_wr_ctrl
  import ifc_pkg::*;
(
  input  logic            wrEn,
  input  logic            clearOnly,
  input  logic [NSRC-1:0] wrBits,
  output wr_strobe_t      strb
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (clearOnly) begin
        strb.clrMask = wrBits;
      end else begin
        strb.setMask = wrBits;
        strb.clrMask = ~wrBits;
      end
    end
  end
endmodule

// File: rtl/ifc_flag_dp.sv
`timescale 1ns/1ps
module ifc_flag_dp
  import ifc_pkg::*;
#(
  parameter logic [NSRC-1:0] FLAG_INIT = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  wr_strobe_t      strb,
  input  logic [NSRC-1:0] evtSet,
  input  logic [NSRC-1:0] dmaRoute,
  input  logic [NSRC-1:0] dmaDone,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] eligible
);
  localparam logic [NSRC-1:0] DMA_SRC = dma_src_mask();

  logic [NSRC-1:0] xferDone;
  logic [NSRC-1:0] routed;
  logic [NSRC-1:0] flagsNext;
  logic [NSRC-1:0] xferNext;

  assign routed = dmaRoute & DMA_SRC;

  // An event beats a clear in the same cycle
  assign flagsNext = evtSet | strb.setMask | (flags & ~strb.clrMask);
  // Completion is remembered while the flag stays up; a new event re-arms the hold
  assign xferNext  = ~evtSet & flags & (dmaDone | xferDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags    <= FLAG_INIT;
      xferDone <= '0;
    end else begin
      flags    <= flagsNext;
      xferDone <= xferNext;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    assign eligible[i] = flags[i] & (~routed[i] | xferDone[i]);
  end

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> ((flags & $past(evtSet)) == $past(evtSet)));

  // R3
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet == '0 && strb == '0) |=> $stable(flags));

  // R9
  routed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evtSet & routed) != '0) |=> ((eligible & routed & $past(evtSet & routed)) == '0));
endmodule

// File: rtl/ifc_arbiter.sv
`timescale 1ns/1ps
module ifc_arbiter
  import ifc_pkg::*;
(
  input  logic [NSRC-1:0]        eligible,
  input  logic [NSRC-1:0]        srcEnable,
  input  logic [NSRC*PRIO_W-1:0] srcPrio,
  input  logic                   globalIe,
  input  logic [PRIO_W-1:0]      cpuLevel,
  output logic                   irqReq,
  output logic [PRIO_W-1:0]      irqLevel,
  output logic [SRC_IDX_W-1:0]   irqSrc
);
  logic [PRIO_W-1:0] prio [NSRC];
  logic [NSRC-1:0]   cand;

  for (genvar i = 0; i < NSRC; i++) begin : g_cand
    assign prio[i] = srcPrio[i*PRIO_W +: PRIO_W];
    assign cand[i] = eligible[i] & srcEnable[i] & (prio[i] > cpuLevel);
  end

  logic                 bestHit;
  logic [PRIO_W-1:0]    bestLvl;
  logic [SRC_IDX_W-1:0] bestIdx;

  // Strictly greater keeps the lowest index on ties
  always_comb begin
    bestHit = 1'b0;
    bestLvl = '0;
    bestIdx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!bestHit || prio[i] > bestLvl)) begin
        bestHit = 1'b1;
        bestLvl = prio[i];
        bestIdx = SRC_IDX_W'(i);
      end
    end
  end

  assign irqReq   = globalIe & bestHit;
  assign irqLevel = irqReq ? bestLvl : '0;
  assign irqSrc   = irqReq ? bestIdx : '0;
endmodule

// File: rtl/ifc_flag_ctrl.sv
`timescale 1ns/1ps
module ifc_flag_ctrl
  import ifc_pkg::*;
#(
  parameter logic [NSRC-1:0] FLAG_INIT = '0,
  parameter int              DATA_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NSRC-1:0]        evtSet,
  input  logic                   wrEn,
  input  logic [NSRC-1:0]        wrData,
  input  logic                   clearOnly,
  output logic [DATA_W-1:0]      rdData,
  input  logic [NSRC-1:0]        srcEnable,
  input  logic [NSRC*PRIO_W-1:0] srcPrio,
  input  logic                   globalIe,
  input  logic [PRIO_W-1:0]      cpuLevel,
  input  logic [NSRC-1:0]        dmaRoute,
  input  logic [NSRC-1:0]        dmaDone,
  output logic                   irqReq,
  output logic [PRIO_W-1:0]      irqLevel,
  output logic [SRC_IDX_W-1:0]   irqSrc
);
  wr_strobe_t      strb;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] eligible;

  ifc_wr_ctrl u_ctrl (
    .wrEn      (wrEn),
    .clearOnly (clearOnly),
    .wrBits    (wrData),
    .strb      (strb)
  );

  ifc_flag_dp #(.FLAG_INIT(FLAG_INIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .evtSet   (evtSet),
    .dmaRoute (dmaRoute),
    .dmaDone  (dmaDone),
    .flags    (flags),
    .eligible (eligible)
  );

  ifc_arbiter u_arb (
    .eligible  (eligible),
    .srcEnable (srcEnable),
    .srcPrio   (srcPrio),
    .globalIe  (globalIe),
    .cpuLevel  (cpuLevel),
    .irqReq    (irqReq),
    .irqLevel  (irqLevel),
    .irqSrc    (irqSrc)
  );

  assign rdData = DATA_W'(flags);

  // R4
  clear_only_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && clearOnly) |=> ((flags & ~$past(flags) & ~$past(evtSet)) == '0));

  // R7
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> globalIe);

  // R7
  irq_above_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLevel > cpuLevel));

  // R7
  irq_src_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (srcEnable[irqSrc] && flags[irqSrc]));
endmodule

// File: tb/tb_ifc_flag_ctrl.sv
`timescale 1ns/1ps
module tb_ifc_flag_ctrl;
  localparam int NS = 6;
  localparam int PW = 3;
  localparam int DW = 8;
  localparam logic [NS-1:0] INIT = 6'b100101;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS-1:0] evtSet, wrData, srcEnable, dmaRoute, dmaDone;
  logic          wrEn, clearOnly, globalIe;
  logic [NS*PW-1:0] srcPrio;
  logic [PW-1:0] cpuLevel;
  logic [DW-1:0] rdData;
  logic          irqReq;
  logic [PW-1:0] irqLevel;
  logic [2:0]    irqSrc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural model state
  bit mF [NS];
  bit mD [NS];

  ifc_flag_ctrl #(.FLAG_INIT(INIT), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .evtSet(evtSet), .wrEn(wrEn), .wrData(wrData),
    .clearOnly(clearOnly), .rdData(rdData), .srcEnable(srcEnable),
    .srcPrio(srcPrio), .globalIe(globalIe), .cpuLevel(cpuLevel),
    .dmaRoute(dmaRoute), .dmaDone(dmaDone), .irqReq(irqReq),
    .irqLevel(irqLevel), .irqSrc(irqSrc)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int prioOf(int i);
    return int'(srcPrio[i*PW +: PW]);
  endfunction

  function automatic int modelRead();
    int v = 0;
    for (int i = 0; i < NS; i++) if (mF[i]) v += (1 << i);
    return v;
  endfunction

  task automatic compareAll();
    int best = -1;
    int bestP = 0;
    for (int i = 0; i < NS; i++) begin
      bit routedM = ((i % 3) != 0) && dmaRoute[i];
      bit elig = mF[i] && (!routedM || mD[i]);
      if (elig && srcEnable[i] && prioOf(i) > int'(cpuLevel) && (best < 0 || prioOf(i) > bestP)) begin
        best = i;
        bestP = prioOf(i);
      end
    end
    if (!globalIe) best = -1;
    chk("R1 rdData", int'(rdData), modelRead());
    chk("R7 irqReq", int'(irqReq), (best >= 0) ? 1 : 0);
    chk("R8 irqLevel", int'(irqLevel), (best >= 0) ? bestP : 0);
    chk("R8 irqSrc", int'(irqSrc), (best >= 0) ? best : 0);
  endtask

  // One clock: compare, advance model, end at the next falling edge
  task automatic step();
    bit nF [NS];
    bit nD [NS];
    #1;
    compareAll();
    for (int i = 0; i < NS; i++) begin
      bit clr = wrEn && (clearOnly ? wrData[i] : !wrData[i]);
      bit set = wrEn && !clearOnly && wrData[i];
      nF[i] = evtSet[i] || set || (mF[i] && !clr);
      nD[i] = !evtSet[i] && mF[i] && (dmaDone[i] || mD[i]);
    end
    @(posedge clk);
    for (int i = 0; i < NS; i++) begin
      mF[i] = rstN ? nF[i] : INIT[i];
      mD[i] = rstN ? nD[i] : 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic idleIn();
    evtSet = '0; wrEn = 0; wrData = '0; dmaDone = '0;
  endtask

  task automatic setPrio(int i, int p);
    srcPrio[i*PW +: PW] = PW'(p);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; idleIn(); clearOnly = 1; srcEnable = '0; srcPrio = '0;
    globalIe = 0; cpuLevel = '0; dmaRoute = '0;
    for (int i = 0; i < NS; i++) begin mF[i] = INIT[i]; mD[i] = 0; end
    @(negedge clk);
    repeat (3) step();
    rstN = 1;
    step();

    // R10: stale power-up flags are visible and request
    chk("R10 reset flags", int'(rdData), int'(INIT));
    srcEnable = '1; globalIe = 1; cpuLevel = 0;
    for (int i = 0; i < NS; i++) setPrio(i, 7);
    #1;
    chk("R10 stale request", int'(irqReq), 1);
    chk("R10 stale src", int'(irqSrc), 0);
    step();

    // R4: clear-only, write ones
    wrEn = 1; wrData = 6'h3F; clearOnly = 1;
    step(); idleIn();
    chk("R4 clear ones", int'(rdData), 0);
    chk("R4 no request", int'(irqReq), 0);

    // R2: event sets flag with its enable off
    srcEnable = '0; evtSet = 6'b010000;
    step(); idleIn();
    chk("R2 event sets", int'(rdData), 'h10);
    chk("R2 no request when disabled", int'(irqReq), 0);

    // R3: holds without write
    repeat (3) step();
    chk("R3 hold", int'(rdData), 'h10);

    // R4: writing zero in clear-only mode does nothing
    wrEn = 1; wrData = '0; clearOnly = 1;
    step(); idleIn();
    chk("R4 zero ignored", int'(rdData), 'h10);

    // R5: read/write mode loads the value
    wrEn = 1; wrData = 6'b000011; clearOnly = 0;
    step(); idleIn();
    chk("R5 load", int'(rdData), 'h03);

    // R6: event wins against a clear in the same cycle
    wrEn = 1; wrData = 6'b000001; clearOnly = 1; evtSet = 6'b000001;
    step(); idleIn();
    chk("R6 set wins", int'(rdData), 'h03);

    // R7: strict level compare, global enable
    srcEnable = '1; setPrio(0, 2); setPrio(1, 5); cpuLevel = 5;
    #1; chk("R7 level equal blocks", int'(irqReq), 0);
    step();
    cpuLevel = 4;
    #1; chk("R7 above level", int'(irqSrc), 1);
    chk("R8 level out", int'(irqLevel), 5);
    step();
    globalIe = 0;
    #1; chk("R7 global off", int'(irqReq), 0);
    step();
    globalIe = 1;

    // R8: tie goes to lowest index
    setPrio(0, 5); cpuLevel = 1;
    #1; chk("R8 tie low index", int'(irqSrc), 0);
    step();

    // R3: request recurs while flag stays set
    globalIe = 0; step(); globalIe = 1;
    #1; chk("R3 recurs", int'(irqReq), 1);
    step();

    // R9: routed DMA flag held until completion
    wrEn = 1; wrData = 6'h3F; clearOnly = 1;
    step(); idleIn();
    cpuLevel = 0; srcEnable = 6'b000011; setPrio(1, 6); setPrio(0, 7);
    dmaRoute = 6'b000010; evtSet = 6'b000010;
    step(); idleIn();
    chk("R9 held", int'(irqReq), 0);
    step();
    chk("R9 still held", int'(irqReq), 0);
    dmaDone = 6'b000010;
    step(); idleIn();
    chk("R9 after done", int'(irqSrc), 1);
    chk("R9 after done req", int'(irqReq), 1);
    // R9: routing bit on a complete/error source is ignored
    dmaRoute = 6'b000011; evtSet = 6'b000001;
    step(); idleIn();
    chk("R9 route ignored", int'(irqSrc), 0);
    chk("R9 route ignored req", int'(irqReq), 1);

    // Random mix, model compared every clock (R1..R9)
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NS; i++) begin
        evtSet[i]  = ($urandom % 8) == 0;
        dmaDone[i] = ($urandom % 6) == 0;
      end
      wrEn = ($urandom % 4) == 0;
      wrData = NS'($urandom);
      clearOnly = ($urandom % 2) == 0;
      if ((n % 16) == 0) begin
        srcEnable = NS'($urandom);
        srcPrio = (NS*PW)'($urandom);
        dmaRoute = NS'($urandom);
        cpuLevel = PW'($urandom % 4);
      end
      globalIe = ($urandom % 8) != 0;
      step();
    end
    idleIn();
    step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule